// File: doc/BRIEF.md
# Channel and Die Select Dehasher

This block takes a physical address whose channel-select and die-select bits were hashed by the memory fabric and restores the plain interleave bits. Up to five channel-select bits and up to two die-select bits are recovered. Each recovered bit is the stored bit XORed with a set of higher address bits. Five enables pick which address ranges take part: 4K, 64K, 2M, 1G and 1T.

The caller gives the channel count and the die count as log2 codes, the interleave start position, the socket count as a log2 code, and the enables. A two-stage pipeline first corrects the channel bits and then the die bits. The die stage works on the address as the channel stage left it. The result leaves with a valid strobe two cycles after the input. A configuration outside the supported range raises an error flag and passes the address through untouched.

Top module: `chan_die_dehasher`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. Every accepted address appears on `out_addr` two cycles after it was presented.
- R2: No address bit other than bits 8, 9, 10, 11, 12, 13 and 14 is ever changed.
- R3: For each channel index i below `chan_log2`, the target bit is 8+i, except that i=4 targets bit 14. That bit is inverted when the XOR of its enabled terms is 1. The terms are bit 15+i (64K, `hash_en[1]`), bit 22+i (2M, `hash_en[2]`), bit 29+i (1G, `hash_en[3]`), and both bits 36+i and 43+i (1T, `hash_en[4]`). Channel indices at or above `chan_log2` leave their target bit unchanged.
- R4: A 4K term, bit 12+i gated by `hash_en[0]`, enters the channel XOR only for indices 0, 1 and 2. The channel stage reads bits 12 to 14 as they arrive, before any die correction.
- R5: For each die index j below `die_log2`, bit 12+j is inverted when the XOR of its enabled terms is 1. The terms are bit 20+j (64K), bit 27+j (2M), bit 34+j (1G) and bit 41+j (1T). The 4K enable has no effect on die bits.
- R6: With all five enables clear, `out_addr` equals the input address for every supported configuration.
- R7: A configuration is unsupported when any of these holds: `ilv_pos` is not 8, `sock_log2` is not 0, `chan_log2` is outside 3 to 5, or `die_log2` is above 2. An unsupported configuration gives `out_err`=1 with `out_addr` equal to the input address. A supported one gives `out_err`=0.
- R8: During and right after synchronous reset, `out_valid`, `out_err` and `out_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input address and configuration are valid |
| in_addr | input | 48 | Hashed physical address |
| chan_log2 | input | 3 | log2 of channel count (3 to 5) |
| die_log2 | input | 2 | log2 of die count (0 to 2) |
| sock_log2 | input | 2 | log2 of socket count (must be 0) |
| ilv_pos | input | 6 | Interleave start bit (must be 8) |
| hash_en | input | 5 | Enables: [0] 4K, [1] 64K, [2] 2M, [3] 1G, [4] 1T |
| out_valid | output | 1 | Result valid |
| out_addr | output | 48 | Dehashed address |
| out_err | output | 1 | Unsupported configuration |

## Verification
The assertions assume the configuration inputs are stable whenever `in_valid` is high. They also assume the address is a known value in those cycles. The bench only changes these inputs on the falling edge, and it drives them before raising `in_valid`, so the assumptions hold.

The supported space is swept in full: every channel code, every die code and all 32 enable patterns, each against several address patterns. Each unsupported field is then violated one at a time.

// File: rtl/dh_pkg.sv
package dh_pkg;

    localparam int ADDR_W        = 48;
    localparam int CHAN_BITS_MAX = 5;
    localparam int DIE_BITS_MAX  = 2;
    localparam int MIN_CHAN_LOG2 = 3;
    localparam int ILV_BIT       = 8;

    // channel chain offsets
    localparam int CH_BASE0   = 8;
    localparam int CH_SKIP_I  = 4;
    localparam int CH_SKIP_B  = 14;
    localparam int CH_K4_LAST = 2;
    localparam int CH_K4      = 12;
    localparam int CH_K64     = 15;
    localparam int CH_M2      = 22;
    localparam int CH_G1      = 29;
    localparam int CH_T1A     = 36;
    localparam int CH_T1B     = 43;

    // die chain offsets
    localparam int DIE_BASE0 = 12;
    localparam int DIE_K64   = 20;
    localparam int DIE_M2    = 27;
    localparam int DIE_G1    = 34;
    localparam int DIE_T1    = 41;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [2:0]        chan_code_t;
    typedef logic [1:0]        die_code_t;

    typedef struct packed {
        logic t1;
        logic g1;
        logic m2;
        logic k64;
        logic k4;
    } hash_en_t;

    typedef struct packed {
        logic      valid;
        logic      err;
        addr_t     addr;
        die_code_t die_code;
        hash_en_t  en;
    } mid_stage_t;

    function automatic int chan_base(int i);
        return (i == CH_SKIP_I) ? CH_SKIP_B : CH_BASE0 + i;
    endfunction

    function automatic addr_t chan_mask();
        addr_t m = '0;
        for (int i = 0; i < CHAN_BITS_MAX; i++) m[chan_base(i)] = 1'b1;
        return m;
    endfunction

    function automatic addr_t die_mask();
        addr_t m = '0;
        for (int j = 0; j < DIE_BITS_MAX; j++) m[DIE_BASE0 + j] = 1'b1;
        return m;
    endfunction

    function automatic logic cfg_ok(logic [5:0] pos, logic [1:0] sock,
                                    chan_code_t cc, die_code_t dc);
        return (pos == 6'(ILV_BIT)) && (sock == 2'd0) &&
               (cc >= 3'(MIN_CHAN_LOG2)) && (cc <= 3'(CHAN_BITS_MAX)) &&
               (dc <= 2'(DIE_BITS_MAX));
    endfunction

endpackage

// File: rtl/dh_chan_stage.sv
module dh_chan_stage
    import dh_pkg::*;
#(
    parameter int NBITS = CHAN_BITS_MAX
) (
    input  addr_t      addr_i,
    input  chan_code_t code_i,
    input  hash_en_t   en_i,
    output addr_t      addr_o
);

    logic [NBITS-1:0] flip;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic term_k4;
        if (i <= CH_K4_LAST) begin : g_k4
            assign term_k4 = addr_i[CH_K4 + i] & en_i.k4;
        end else begin : g_no_k4
            assign term_k4 = 1'b0;
        end
        assign flip[i] = (code_i > 3'(i)) &
                         (term_k4 ^
                          (addr_i[CH_K64 + i] & en_i.k64) ^
                          (addr_i[CH_M2  + i] & en_i.m2)  ^
                          (addr_i[CH_G1  + i] & en_i.g1)  ^
                          ((addr_i[CH_T1A + i] ^ addr_i[CH_T1B + i]) & en_i.t1));
    end

    always_comb begin
        addr_o = addr_i;
        for (int i = 0; i < NBITS; i++)
            addr_o[chan_base(i)] = addr_i[chan_base(i)] ^ flip[i];
    end

endmodule

// File: rtl/dh_die_stage.sv
module dh_die_stage
    import dh_pkg::*;
#(
    parameter int NBITS = DIE_BITS_MAX
) (
    input  addr_t     addr_i,
    input  die_code_t code_i,
    input  hash_en_t  en_i,
    output addr_t     addr_o
);

    logic [NBITS-1:0] flip;

    for (genvar j = 0; j < NBITS; j++) begin : g_bit
        assign flip[j] = (code_i > 2'(j)) &
                         ((addr_i[DIE_K64 + j] & en_i.k64) ^
                          (addr_i[DIE_M2  + j] & en_i.m2)  ^
                          (addr_i[DIE_G1  + j] & en_i.g1)  ^
                          (addr_i[DIE_T1  + j] & en_i.t1));
    end

    always_comb begin
        addr_o = addr_i;
        for (int j = 0; j < NBITS; j++)
            addr_o[DIE_BASE0 + j] = addr_i[DIE_BASE0 + j] ^ flip[j];
    end

endmodule

// File: rtl/chan_die_dehasher.sv
module chan_die_dehasher
    import dh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [2:0]        chan_log2,
    input  logic [1:0]        die_log2,
    input  logic [1:0]        sock_log2,
    input  logic [5:0]        ilv_pos,
    input  logic [4:0]        hash_en,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_err
);

    localparam addr_t CH_MASK  = chan_mask();
    localparam addr_t DIE_MASK = die_mask();

    hash_en_t   en_in;
    addr_t      chan_addr, die_addr;
    logic       cfg_bad;
    mid_stage_t mid_q;

    assign en_in   = hash_en_t'(hash_en);
    assign cfg_bad = !cfg_ok(ilv_pos, sock_log2, chan_log2, die_log2);

    dh_chan_stage #(.NBITS(CHAN_BITS_MAX)) i_chan (
        .addr_i (in_addr),
        .code_i (chan_log2),
        .en_i   (en_in),
        .addr_o (chan_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q <= '0;
        end else begin
            mid_q.valid <= in_valid;
            if (in_valid) begin
                mid_q.err      <= cfg_bad;
                mid_q.addr     <= cfg_bad ? in_addr : chan_addr;
                mid_q.die_code <= die_log2;
                mid_q.en       <= en_in;
            end
        end
    end

    dh_die_stage #(.NBITS(DIE_BITS_MAX)) i_die (
        .addr_i (mid_q.addr),
        .code_i (mid_q.die_code),
        .en_i   (mid_q.en),
        .addr_o (die_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= mid_q.valid;
            if (mid_q.valid) begin
                out_err  <= mid_q.err;
                out_addr <= mid_q.err ? mid_q.addr : die_addr;
            end
        end
    end

    AST_MID_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> mid_q.valid); // R1
    AST_OUT_VALID: assert property (@(posedge clk) disable iff (rst)
        mid_q.valid |=> out_valid); // R1
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mid_q.valid |=> !out_valid); // R1
    AST_CHAN_SCOPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((mid_q.addr ^ $past(in_addr)) & ~CH_MASK) == '0); // R2
    AST_DIE_SCOPE: assert property (@(posedge clk) disable iff (rst)
        mid_q.valid |=> ((out_addr ^ $past(mid_q.addr)) & ~DIE_MASK) == '0); // R2
    AST_NOHASH_ID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hash_en == '0) |=> mid_q.addr == $past(in_addr)); // R6
    AST_ERR_MID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_bad) |=> (mid_q.err && mid_q.addr == $past(in_addr))); // R7
    AST_ERR_OUT: assert property (@(posedge clk) disable iff (rst)
        (mid_q.valid && mid_q.err) |=> (out_err && out_addr == $past(mid_q.addr))); // R7

endmodule

// File: tb/test_chan_die_dehasher.sv
`timescale 1ns/1ps
module test_chan_die_dehasher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [47:0] in_addr = '0;
    logic [2:0]  chan_log2 = 3'd3;
    logic [1:0]  die_log2 = 2'd0;
    logic [1:0]  sock_log2 = 2'd0;
    logic [5:0]  ilv_pos = 6'd8;
    logic [4:0]  hash_en = '0;
    logic        out_valid;
    logic [47:0] out_addr;
    logic        out_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [47:0] CHM = 48'h0000_0000_4F00;
    localparam logic [47:0] DIM = 48'h0000_0000_3000;

    always #2.5 clk = ~clk;

    chan_die_dehasher i_chan_die_dehasher (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .chan_log2(chan_log2), .die_log2(die_log2), .sock_log2(sock_log2),
        .ilv_pos(ilv_pos), .hash_en(hash_en),
        .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
    );

    function automatic logic [47:0] model(logic [47:0] a, int cl, int dl, logic [4:0] en);
        logic [47:0] r = a;
        for (int i = 0; i < 5; i++) begin
            if (i < cl) begin
                int  b = (i == 4) ? 14 : 8 + i;
                logic x = 1'b0;
                if (i <= 2 && en[0]) x ^= a[12 + i];
                if (en[1]) x ^= a[15 + i];
                if (en[2]) x ^= a[22 + i];
                if (en[3]) x ^= a[29 + i];
                if (en[4]) x ^= a[36 + i] ^ a[43 + i];
                r[b] ^= x;
            end
        end
        for (int j = 0; j < 2; j++) begin
            if (j < dl) begin
                logic x = 1'b0;
                if (en[1]) x ^= r[20 + j];
                if (en[2]) x ^= r[27 + j];
                if (en[3]) x ^= r[34 + j];
                if (en[4]) x ^= r[41 + j];
                r[12 + j] ^= x;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [47:0] a);
        @(negedge clk);
        in_addr  = a;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    logic [47:0] pats [6];

    initial begin
        pats[0] = 48'hFFFF_FFFF_FFFF;
        pats[1] = 48'h5555_5555_5555;
        pats[2] = 48'hAAAA_AAAA_AAAA;
        pats[3] = 48'h1234_5678_9ABC;
        pats[4] = 48'h8F0E_D1C3_B7A5;
        pats[5] = 48'h0F0F_F0F0_3C3C;

        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 valid", {47'd0, out_valid}, 48'd0);
        check("R8 err",   {47'd0, out_err},   48'd0);
        check("R8 addr",  out_addr,           48'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after release", {46'd0, out_valid, out_err}, 48'd0);

        for (int cl = 3; cl <= 5; cl++) begin
            for (int dl = 0; dl <= 2; dl++) begin
                for (int en = 0; en < 32; en++) begin
                    for (int p = 0; p < 6; p++) begin
                        logic [47:0] exp;
                        chan_log2 = 3'(cl);
                        die_log2  = 2'(dl);
                        hash_en   = 5'(en);
                        exp = model(pats[p], cl, dl, 5'(en));
                        apply(pats[p]);
                        check("R1 valid", {47'd0, out_valid}, 48'd1);
                        check("R7 err clear", {47'd0, out_err}, 48'd0);
                        check("R2 untouched", out_addr & ~(CHM | DIM), pats[p] & ~(CHM | DIM));
                        if (en[0])
                            check("R4 chan bits", out_addr & CHM, exp & CHM);
                        else
                            check("R3 chan bits", out_addr & CHM, exp & CHM);
                        check("R5 die bits", out_addr & DIM, exp & DIM);
                        if (en == 0)
                            check("R6 identity", out_addr, pats[p]);
                    end
                end
            end
        end

        // R1: idle cycle after a pulse drops out_valid
        @(negedge clk);
        check("R1 idle", {47'd0, out_valid}, 48'd0);

        // R1: back-to-back stream, one result per cycle in order
        chan_log2 = 3'd5; die_log2 = 2'd2; hash_en = 5'h1F;
        @(negedge clk); in_addr = pats[3]; in_valid = 1'b1;
        @(negedge clk); in_addr = pats[4];
        @(negedge clk); in_addr = pats[5];
        check("R1 stream0", out_addr, model(pats[3], 5, 2, 5'h1F));
        @(negedge clk); in_valid = 1'b0;
        check("R1 stream1", out_addr, model(pats[4], 5, 2, 5'h1F));
        @(negedge clk);
        check("R1 stream2", out_addr, model(pats[5], 5, 2, 5'h1F));
        check("R1 stream valid", {47'd0, out_valid}, 48'd1);

        // R7: one unsupported field at a time
        for (int k = 0; k < 5; k++) begin
            chan_log2 = 3'd4; die_log2 = 2'd1; sock_log2 = 2'd0; ilv_pos = 6'd8; hash_en = 5'h1F;
            case (k)
                0: ilv_pos   = 6'd9;
                1: sock_log2 = 2'd1;
                2: chan_log2 = 3'd2;
                3: chan_log2 = 3'd6;
                default: die_log2 = 2'd3;
            endcase
            apply(pats[0] ^ 48'(k));
            check("R7 err set", {47'd0, out_err}, 48'd1);
            check("R7 passthrough", out_addr, pats[0] ^ 48'(k));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule